// File: doc/BRIEF.md
# Host Mailbox Register Exchange

This block passes single 16-bit words in both directions between an external host processor and an on-chip processor. The host reaches it through an asynchronous parallel port: an active-low chip select, active-low read and write strobes, a select line that picks the data word (high) or the status word (low), and a 16-bit bidirectional data bus. The on-chip side sees the inbound word, a write port for the outbound word, a status vector, and two interrupt pulses.

Each direction has its own ownership flag. The flag is set by the producing side and only the consuming side can clear it. The host writes the inbound word, which sets the inbound-full flag. The on-chip side accepts the word, which clears that flag and sends a pulse back to the host. The on-chip side loads the outbound word, which sets the outbound-full flag. The host reads it, which clears the flag and, when enabled, interrupts the on-chip processor. So interrupts mark the moment the far side has consumed a word, not the moment data arrives.

Host strobes pass through two-flop synchronizers into a port state machine. Its states are PS_IDLE (waiting for a strobe), PS_WRITE (one-cycle write action), PS_READ (one-cycle read action) and PS_HOLD (waiting until the strobes are released). Its transitions are: PS_IDLE to PS_WRITE when chip select and write are both low; PS_IDLE to PS_READ when chip select and read are both low (write is checked first); PS_WRITE and PS_READ to PS_HOLD unconditionally; PS_HOLD to PS_IDLE once chip select is high or both strobes are high. Because of this, each strobe assertion causes exactly one register action.

Top module: `hmbx_exchange`

## Requirements
- R1: After reset the status vector is 0, both interrupt outputs are low, and the inbound and outbound words are 0.
- R2: A host write with select high, while inbound-full is clear, stores the bus word as the inbound word and sets inbound-full (status bit 0). This takes effect no later than 5 clock cycles after the strobe falls.
- R3: A host write with select high while inbound-full is set leaves the inbound word unchanged and sets the sticky overrun flag (status bit 2).
- R4: When the on-chip side accepts the word (`cpu_take`) while inbound-full is set, inbound-full and overrun are cleared and `host_irq` pulses high for one cycle. An accept while inbound-full is clear has no effect.
- R5: `cpu_put` loads the outbound word and sets outbound-full (status bit 1). A put while outbound-full is already set overwrites the word.
- R6: While chip select and read are both low, the block drives the bus with the outbound word when select is high, and with the status word (bit 0 inbound-full, bit 1 outbound-full, bit 2 overrun, other bits 0) when select is low.
- R7: A host read with select high while outbound-full is set clears outbound-full. If `irq_en` is high, `cpu_irq` also pulses high for one cycle; if it is low, there is no pulse.
- R8: One strobe assertion causes exactly one action, however long the strobe is held low.
- R9: A host read of status, a host write with select low, and a host data read while outbound-full is clear change no state and raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_cs_n | input | 1 | Host chip select, active low |
| ext_rd_n | input | 1 | Host read strobe, active low |
| ext_wr_n | input | 1 | Host write strobe, active low |
| ext_sel | input | 1 | Host word select: 1 selects data, 0 selects status |
| ext_data | inout | 16 | Host bidirectional data bus |
| cpu_take | input | 1 | On-chip side accepts the inbound word |
| cpu_in_word | output | 16 | Inbound word |
| cpu_put | input | 1 | On-chip side loads the outbound word |
| cpu_out_word | input | 16 | Outbound word to load |
| irq_en | input | 1 | Enable for the on-chip consumption interrupt |
| cpu_status | output | 3 | {overrun, outbound-full, inbound-full} |
| cpu_irq | output | 1 | One-cycle pulse: the host consumed the outbound word |
| host_irq | output | 1 | One-cycle pulse: the on-chip side consumed the inbound word |

## Verification
The bench goes after the following corner cases, with a fixed-seed random mix of all six operations running alongside them:
- A write into a full inbound register. A design that lets it through would corrupt the pending word and never set overrun.
- A strobe held low for many cycles. A machine that re-arms while the strobe is still low would apply the write twice and report a false overrun.
- A data read when no word is pending. This must not raise an interrupt.
- A read made while the enable is low. It must clear the flag without a pulse; a design that confuses the two would either lose pulses or leave the outbound word looking pending.
- An accept on an empty inbound register. It must not send a spurious pulse to the host.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;
    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_WRITE = 2'd1,
        PS_READ  = 2'd2,
        PS_HOLD  = 2'd3
    } port_state_t;

    localparam int ST_IN_FULL  = 0;
    localparam int ST_OUT_FULL = 1;
    localparam int ST_OVERRUN  = 2;
    localparam int ST_BITS     = 3;
endpackage

// File: rtl/hmbx_sync.sv
module hmbx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], async_in[b]};
        end
        assign sync_out[b] = chain[LAST];
    end
endmodule

// File: rtl/hmbx_port_fsm.sv
module hmbx_port_fsm
    import hmbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n_s,
    input  logic        rd_n_s,
    input  logic        wr_n_s,
    output logic        do_write,
    output logic        do_read,
    output port_state_t state
);
    port_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PS_IDLE: begin
                if (!cs_n_s && !wr_n_s)      state_nx = PS_WRITE;
                else if (!cs_n_s && !rd_n_s) state_nx = PS_READ;
            end
            PS_WRITE: state_nx = PS_HOLD;
            PS_READ:  state_nx = PS_HOLD;
            PS_HOLD: begin
                if (cs_n_s || (rd_n_s && wr_n_s)) state_nx = PS_IDLE;
            end
        endcase
    end

    always_comb begin
        do_write = 1'b0;
        do_read  = 1'b0;
        unique case (state)
            PS_WRITE: do_write = 1'b1;
            PS_READ:  do_read  = 1'b1;
            PS_IDLE, PS_HOLD: ;
        endcase
    end

    // R8
    one_action_per_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_WRITE || state == PS_READ) |=> (state == PS_HOLD));
endmodule

// File: rtl/hmbx_regs.sv
module hmbx_regs
    import hmbx_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               do_write,
    input  logic               do_read,
    input  logic               sel,
    input  logic [DW-1:0]      bus_in,
    input  logic               cpu_take,
    input  logic               cpu_put,
    input  logic [DW-1:0]      put_word,
    input  logic               irq_en,
    output logic [DW-1:0]      in_word,
    output logic [DW-1:0]      out_word,
    output logic [ST_BITS-1:0] status,
    output logic               cpu_irq,
    output logic               host_irq
);
    logic in_full, out_full, overrun;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_word  <= '0;
            out_word <= '0;
            in_full  <= 1'b0;
            out_full <= 1'b0;
            overrun  <= 1'b0;
            cpu_irq  <= 1'b0;
            host_irq <= 1'b0;
        end else begin
            cpu_irq  <= 1'b0;
            host_irq <= 1'b0;
            if (do_write && sel) begin
                if (in_full) overrun <= 1'b1;
                else begin
                    in_word <= bus_in;
                    in_full <= 1'b1;
                end
            end
            if (cpu_take && in_full) begin
                in_full  <= 1'b0;
                overrun  <= 1'b0;
                host_irq <= 1'b1;
            end
            if (do_read && sel && out_full) begin
                out_full <= 1'b0;
                cpu_irq  <= irq_en;
            end
            if (cpu_put) begin
                out_word <= put_word;
                out_full <= 1'b1;
            end
        end
    end

    always_comb begin
        status              = '0;
        status[ST_IN_FULL]  = in_full;
        status[ST_OUT_FULL] = out_full;
        status[ST_OVERRUN]  = overrun;
    end

    // R3
    full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_write && in_full) |=> $stable(in_word));
    // R4
    host_irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> !in_full);
    // R7
    cpu_irq_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> $past(irq_en));
    // R7
    cpu_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |=> !cpu_irq);
    // R2
    in_full_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_full) |-> $past(do_write));
endmodule

// File: rtl/hmbx_exchange.sv
module hmbx_exchange
    import hmbx_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_cs_n,
    input  logic               ext_rd_n,
    input  logic               ext_wr_n,
    input  logic               ext_sel,
    inout  wire  [DW-1:0]      ext_data,
    input  logic               cpu_take,
    output logic [DW-1:0]      cpu_in_word,
    input  logic               cpu_put,
    input  logic [DW-1:0]      cpu_out_word,
    input  logic               irq_en,
    output logic [ST_BITS-1:0] cpu_status,
    output logic               cpu_irq,
    output logic               host_irq
);
    logic [2:0]    strobes_s;
    logic          do_write, do_read;
    port_state_t   pstate;
    logic [DW-1:0] out_word, rd_val;

    hmbx_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ext_cs_n, ext_rd_n, ext_wr_n}),
        .sync_out (strobes_s)
    );

    hmbx_port_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (strobes_s[2]),
        .rd_n_s   (strobes_s[1]),
        .wr_n_s   (strobes_s[0]),
        .do_write (do_write),
        .do_read  (do_read),
        .state    (pstate)
    );

    hmbx_regs #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_write (do_write),
        .do_read  (do_read),
        .sel      (ext_sel),
        .bus_in   (ext_data),
        .cpu_take (cpu_take),
        .cpu_put  (cpu_put),
        .put_word (cpu_out_word),
        .irq_en   (irq_en),
        .in_word  (cpu_in_word),
        .out_word (out_word),
        .status   (cpu_status),
        .cpu_irq  (cpu_irq),
        .host_irq (host_irq)
    );

    assign rd_val   = ext_sel ? out_word : DW'(cpu_status);
    assign ext_data = (!ext_cs_n && !ext_rd_n) ? rd_val : 'z;

    // R9
    status_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_read && !ext_sel) |=> $stable(cpu_status));
endmodule

// File: tb/hmbx_exchange_test.sv
`timescale 1ns/1ps
module hmbx_exchange_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, sel = 1'b0;
    logic        tb_oe = 1'b0;
    logic [15:0] tb_drv = '0;
    wire  [15:0] bus;
    logic        take = 1'b0, put = 1'b0, irq_en = 1'b0;
    logic [15:0] put_word = '0;
    logic [15:0] in_word;
    logic [2:0]  status;
    logic        cpu_irq, host_irq;

    int checks = 0, errors = 0;
    int cpu_irq_cnt = 0, host_irq_cnt = 0;
    bit m_in_full, m_out_full, m_ovr;
    logic [15:0] m_in, m_out;
    int m_cpu_irqs = 0, m_host_irqs = 0;

    assign bus = tb_oe ? tb_drv : 'z;
    always #2 clk = ~clk;

    hmbx_exchange uut (
        .clk(clk), .rst_n(rst_n), .ext_cs_n(cs_n), .ext_rd_n(rd_n),
        .ext_wr_n(wr_n), .ext_sel(sel), .ext_data(bus), .cpu_take(take),
        .cpu_in_word(in_word), .cpu_put(put), .cpu_out_word(put_word),
        .irq_en(irq_en), .cpu_status(status), .cpu_irq(cpu_irq),
        .host_irq(host_irq)
    );

    always @(negedge clk) begin
        if (cpu_irq)  cpu_irq_cnt++;
        if (host_irq) host_irq_cnt++;
    end

    function automatic logic [15:0] exp_status();
        return {13'd0, m_ovr, m_out_full, m_in_full};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check(req, {13'd0, status}, exp_status());
        check(req, in_word, m_in);
        check(req, 16'(cpu_irq_cnt), 16'(m_cpu_irqs));
        check(req, 16'(host_irq_cnt), 16'(m_host_irqs));
    endtask

    task automatic ext_write(bit s, logic [15:0] v, int hold);
        @(negedge clk);
        sel = s; tb_drv = v; tb_oe = 1'b1; cs_n = 1'b0; wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
        repeat (5) @(negedge clk);
        tb_oe = 1'b0;
        if (s) begin
            if (m_in_full) m_ovr = 1'b1;
            else begin m_in = v; m_in_full = 1'b1; end
        end
    endtask

    task automatic ext_read(bit s, string req);
        logic [15:0] exp;
        @(negedge clk);
        sel = s; cs_n = 1'b0; rd_n = 1'b0;
        repeat (2) @(negedge clk);
        exp = s ? m_out : exp_status();
        check(req, bus, exp);
        repeat (4) @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (5) @(negedge clk);
        if (s && m_out_full) begin
            m_out_full = 1'b0;
            if (irq_en) m_cpu_irqs++;
        end
    endtask

    task automatic cpu_accept();
        @(negedge clk); take = 1'b1;
        @(negedge clk); take = 1'b0;
        @(negedge clk);
        if (m_in_full) begin
            m_in_full = 1'b0; m_ovr = 1'b0; m_host_irqs++;
        end
    endtask

    task automatic cpu_load(logic [15:0] v);
        @(negedge clk); put = 1'b1; put_word = v;
        @(negedge clk); put = 1'b0;
        @(negedge clk);
        m_out = v; m_out_full = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        m_in = '0; m_out = '0;
        seed = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        ext_write(1'b1, 16'hA5C3, 6);
        check_all("R2 write sets inbound-full");
        ext_read(1'b0, "R6 status read");
        check_all("R9 status read no side effect");
        ext_write(1'b1, 16'h1111, 6);
        check_all("R3 write while full ignored, overrun");
        cpu_accept();
        check_all("R4 accept clears flags");
        cpu_accept();
        check_all("R4 accept on empty no effect");
        ext_write(1'b0, 16'hFFFF, 6);
        check_all("R9 status write ignored");
        ext_write(1'b1, 16'h0F0F, 20);
        check_all("R8 long write strobe single action");
        cpu_accept();
        irq_en = 1'b1;
        ext_read(1'b1, "R9 data read when empty");
        check_all("R9 empty read no irq");
        cpu_load(16'h1234);
        cpu_load(16'hBEEF);
        check_all("R5 put overwrites");
        ext_read(1'b1, "R6 data read");
        check_all("R7 read clears, irq with enable");
        cpu_load(16'h7777);
        irq_en = 1'b0;
        ext_read(1'b1, "R6 data read disabled");
        check_all("R7 read clears, no irq when disabled");

        for (int i = 0; i < 300; i++) begin
            int op;
            op = $urandom_range(0, 5);
            irq_en = 1'($urandom_range(0, 1));
            case (op)
                0: ext_write(1'b1, 16'($urandom), $urandom_range(3, 12));
                1: ext_write(1'b0, 16'($urandom), 6);
                2: ext_read(1'b1, "R6 random data read");
                3: ext_read(1'b0, "R6 random status read");
                4: cpu_accept();
                default: cpu_load(16'($urandom));
            endcase
            check_all("R2 R3 R4 R5 R7 random mix");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule